// File: doc/BRIEF.md
# Transceiver Attribute Command Engine

This block is a bus master that hands one attribute to a transceiver channel. The channel exposes a byte-wide register space on a memory-mapped bus with `waitrequest` and `readdatavalid` flow control. A client presents a 16-bit attribute code, a 16-bit attribute value and a one-cycle start strobe. The engine then runs the full handshake without further help: it writes the four payload bytes into their fixed lanes and writes the launch bit. It reads the acceptance flag, polls the busy bit until the channel finishes, and clears the flag by writing a one to it.

The client can ask for a pre-clear of a stale acceptance flag before the payload goes out. It also gives an upper bound on the number of busy polls. The engine reports completion with a single-cycle `done` pulse, together with one of two error pulses when the channel refused the attribute or stayed busy too long. It also keeps the status byte it read back from the flag register. While a transaction runs, `busy` is high and further start strobes have no effect.

Top module: `attr_cmd_engine`

## Requirements
- R1: The payload is written as four byte writes in this order: value bits 7:0 to address 0x84, value bits 15:8 to 0x85, code bits 7:0 to 0x86, code bits 15:8 to 0x87.
- R2: Directly after the last payload byte, the engine writes 0x01 to address 0x90 (bit 0 is the launch bit).
- R3: When `req_preclear` is high with the start strobe, the first access is a write of 0x80 to address 0x8A, before any payload byte. When it is low, that write is absent.
- R4: After launch the engine reads address 0x8A. If bit 7 of that byte is 0, the transaction ends with `done` and `err_noaccept` pulsing together, and no further bus access follows.
- R5: If the flag is set, the engine reads address 0x8B repeatedly until bit 0 reads 0. It then writes 0x80 to address 0x8A and ends with `done` and neither error.
- R6: The engine issues at most N reads of 0x8B, where N is `poll_limit`, or 1 when `poll_limit` is 0. If all N read busy, it ends with `done` and `err_timeout` and skips the clearing write.
- R7: Only one access is outstanding at a time. Address, write data and the read/write strobes stay unchanged while `avm_waitrequest` is high. A read completes only on a later cycle with `avm_readdatavalid` high, and the byte returned then is what the engine acts on.
- R8: `busy` rises in the cycle after an accepted start strobe and stays high until the cycle in which `done` pulses, where it is low. `done` and each error are single-cycle pulses, and at most one error pulses.
- R9: A start strobe while `busy` is high is ignored. The running transaction keeps its own code and value, and no second transaction follows.
- R10: From a `done` that followed a flag read, `rd_byte` holds the byte read from address 0x8A.
- R11: After reset, `busy`, `done`, both errors, `avm_read` and `avm_write` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe, accepted when idle |
| req_code | input | 16 | Attribute code |
| req_value | input | 16 | Attribute value |
| req_preclear | input | 1 | Clear a stale acceptance flag first |
| poll_limit | input | POLL_W | Maximum busy polls (0 acts as 1) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished pulse |
| err_noaccept | output | 1 | Channel did not take the attribute |
| err_timeout | output | 1 | Busy poll limit exhausted |
| rd_byte | output | 8 | Byte last read from the flag register |
| avm_address | output | ADDR_W | Bus byte address |
| avm_write | output | 1 | Write strobe |
| avm_read | output | 1 | Read strobe |
| avm_writedata | output | 8 | Write data |
| avm_waitrequest | input | 1 | Slave stall |
| avm_readdata | input | 8 | Read data |
| avm_readdatavalid | input | 1 | Read data valid |

## Verification
The assertions assume the slave follows the bus rules. `avm_readdatavalid` comes only for an accepted read, on a cycle after acceptance, and never for a write. The start strobe is a plain synchronous input. The bench responder stalls each access by zero to two cycles and returns read data one or two cycles after acceptance, so all its responses stay inside those rules. It sweeps poll limits, busy lengths, acceptance and pre-clear, and fires start strobes only as single-cycle pulses between clock edges.

// File: rtl/attr_pkg.sv
package attr_pkg;

    localparam logic [15:0] REG_VAL_LO = 16'h0084;
    localparam logic [15:0] REG_VAL_HI = 16'h0085;
    localparam logic [15:0] REG_COD_LO = 16'h0086;
    localparam logic [15:0] REG_COD_HI = 16'h0087;
    localparam logic [15:0] REG_FLAG   = 16'h008A;
    localparam logic [15:0] REG_BUSY   = 16'h008B;
    localparam logic [15:0] REG_GO     = 16'h0090;

    localparam logic [7:0] FLAG_CLR = 8'h80;
    localparam logic [7:0] GO_BIT   = 8'h01;

    typedef enum logic [3:0] {
        S_IDLE, S_PRECLR, S_VLO, S_VHI, S_CLO, S_CHI,
        S_LAUNCH, S_CHECK, S_POLL, S_CLEAR
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_REQ, PH_RDWAIT
    } phase_e;

endpackage

// File: rtl/attr_bus_port.sv
module attr_bus_port #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic              cmd_ready,
    output logic              cmd_done,
    output logic [7:0]        cmd_rdata,
    output logic [ADDR_W-1:0] avm_address,
    output logic              avm_write,
    output logic              avm_read,
    output logic [7:0]        avm_writedata,
    input  logic              avm_waitrequest,
    input  logic [7:0]        avm_readdata,
    input  logic              avm_readdatavalid
);
    import attr_pkg::*;

    typedef struct packed {
        phase_e            ph;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              done;
        logic [7:0]        rdata;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d      = p_q;
        p_d.done = 1'b0;
        case (p_q.ph)
            PH_IDLE: if (cmd_valid) begin
                p_d.ph   = PH_REQ;
                p_d.wr   = cmd_wr;
                p_d.addr = cmd_addr;
                p_d.data = cmd_wdata;
            end
            PH_REQ: if (!avm_waitrequest) begin
                if (p_q.wr) begin
                    p_d.ph   = PH_IDLE;
                    p_d.done = 1'b1;
                end else begin
                    p_d.ph = PH_RDWAIT;
                end
            end
            PH_RDWAIT: if (avm_readdatavalid) begin
                p_d.ph    = PH_IDLE;
                p_d.done  = 1'b1;
                p_d.rdata = avm_readdata;
            end
            default: p_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '{ph: PH_IDLE, wr: 1'b0, addr: '0, data: '0, done: 1'b0, rdata: '0};
        end else begin
            p_q <= p_d;
        end
    end

    assign cmd_ready     = (p_q.ph == PH_IDLE);
    assign cmd_done      = p_q.done;
    assign cmd_rdata     = p_q.rdata;
    assign avm_address   = p_q.addr;
    assign avm_writedata = p_q.data;
    assign avm_write     = (p_q.ph == PH_REQ) &&  p_q.wr;
    assign avm_read      = (p_q.ph == PH_REQ) && !p_q.wr;

    // R7: request fields frozen while the slave stalls
    a_r7_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (avm_read || avm_write) && avm_waitrequest |=>
            $stable(avm_address) && $stable(avm_writedata) &&
            $stable(avm_read) && $stable(avm_write));

    // R7: the sequencer never issues while an access is outstanding
    a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_ready);

endmodule

// File: rtl/attr_seq.sv
module attr_seq #(
    parameter int ADDR_W = 16,
    parameter int POLL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [15:0]       req_code,
    input  logic [15:0]       req_value,
    input  logic              req_preclear,
    input  logic [POLL_W-1:0] poll_limit,
    input  logic              cmd_ready,
    input  logic              cmd_done,
    input  logic [7:0]        cmd_rdata,
    output logic              cmd_valid,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic              err_noaccept,
    output logic              err_timeout,
    output logic [7:0]        rd_byte
);
    import attr_pkg::*;

    localparam int CNT_W = POLL_W + 1;

    typedef struct packed {
        step_e             step;
        logic              sent;
        logic [15:0]       code;
        logic [15:0]       value;
        logic [POLL_W-1:0] limit;
        logic [POLL_W-1:0] cnt;
        logic              busy;
        logic              done;
        logic              e_na;
        logic              e_to;
        logic [7:0]        rdb;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] lim_eff;
    logic [CNT_W-1:0] cnt_next;

    assign lim_eff  = (s_q.limit == '0) ? CNT_W'(1) : {1'b0, s_q.limit};
    assign cnt_next = {1'b0, s_q.cnt} + CNT_W'(1);

    // access selected by the current step
    always_comb begin
        cmd_wr    = 1'b1;
        cmd_addr  = '0;
        cmd_wdata = '0;
        case (s_q.step)
            S_PRECLR: begin cmd_addr = ADDR_W'(REG_FLAG);   cmd_wdata = FLAG_CLR;         end
            S_VLO:    begin cmd_addr = ADDR_W'(REG_VAL_LO); cmd_wdata = s_q.value[7:0];   end
            S_VHI:    begin cmd_addr = ADDR_W'(REG_VAL_HI); cmd_wdata = s_q.value[15:8];  end
            S_CLO:    begin cmd_addr = ADDR_W'(REG_COD_LO); cmd_wdata = s_q.code[7:0];    end
            S_CHI:    begin cmd_addr = ADDR_W'(REG_COD_HI); cmd_wdata = s_q.code[15:8];   end
            S_LAUNCH: begin cmd_addr = ADDR_W'(REG_GO);     cmd_wdata = GO_BIT;           end
            S_CHECK:  begin cmd_addr = ADDR_W'(REG_FLAG);   cmd_wr    = 1'b0;             end
            S_POLL:   begin cmd_addr = ADDR_W'(REG_BUSY);   cmd_wr    = 1'b0;             end
            S_CLEAR:  begin cmd_addr = ADDR_W'(REG_FLAG);   cmd_wdata = FLAG_CLR;         end
            default:  ;
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.e_na = 1'b0;
        s_d.e_to = 1'b0;
        cmd_valid = 1'b0;

        if (s_q.step != S_IDLE && !s_q.sent && cmd_ready) begin
            cmd_valid = 1'b1;
            s_d.sent  = 1'b1;
        end

        if (s_q.step == S_IDLE) begin
            if (req_start) begin
                s_d.code  = req_code;
                s_d.value = req_value;
                s_d.limit = poll_limit;
                s_d.cnt   = '0;
                s_d.sent  = 1'b0;
                s_d.busy  = 1'b1;
                s_d.step  = req_preclear ? S_PRECLR : S_VLO;
            end
        end else if (cmd_done) begin
            s_d.sent = 1'b0;
            case (s_q.step)
                S_PRECLR: s_d.step = S_VLO;
                S_VLO:    s_d.step = S_VHI;
                S_VHI:    s_d.step = S_CLO;
                S_CLO:    s_d.step = S_CHI;
                S_CHI:    s_d.step = S_LAUNCH;
                S_LAUNCH: s_d.step = S_CHECK;
                S_CHECK: begin
                    s_d.rdb = cmd_rdata;
                    if (cmd_rdata[7]) begin
                        s_d.step = S_POLL;
                    end else begin
                        s_d.step = S_IDLE;
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                        s_d.e_na = 1'b1;
                    end
                end
                S_POLL: begin
                    if (!cmd_rdata[0]) begin
                        s_d.step = S_CLEAR;
                    end else if (cnt_next >= lim_eff) begin
                        s_d.step = S_IDLE;
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                        s_d.e_to = 1'b1;
                    end else begin
                        s_d.cnt = cnt_next[POLL_W-1:0];
                    end
                end
                S_CLEAR: begin
                    s_d.step = S_IDLE;
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
                default: s_d.step = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{step: S_IDLE, sent: 1'b0, code: '0, value: '0, limit: '0,
                     cnt: '0, busy: 1'b0, done: 1'b0, e_na: 1'b0, e_to: 1'b0,
                     rdb: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy         = s_q.busy;
    assign done         = s_q.done;
    assign err_noaccept = s_q.e_na;
    assign err_timeout  = s_q.e_to;
    assign rd_byte      = s_q.rdb;

    // R8: busy only falls together with a done pulse
    a_r8_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8: done follows a cycle in which busy was high, and is a single pulse
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy) && !busy);

    // R8: at most one error per transaction end
    a_r8_err_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_noaccept, err_timeout}));

    // R6: the busy-read counter never reaches the effective limit while polling
    a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step == S_POLL) |-> ({1'b0, s_q.cnt} < lim_eff));

    // R9: a strobe during a transaction leaves its payload untouched
    a_r9_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_start) |=> (s_q.code == $past(s_q.code)) &&
                                (s_q.value == $past(s_q.value)));

endmodule

// File: rtl/attr_cmd_engine.sv
module attr_cmd_engine #(
    parameter int ADDR_W = 16,
    parameter int POLL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [15:0]       req_code,
    input  logic [15:0]       req_value,
    input  logic              req_preclear,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              busy,
    output logic              done,
    output logic              err_noaccept,
    output logic              err_timeout,
    output logic [7:0]        rd_byte,
    output logic [ADDR_W-1:0] avm_address,
    output logic              avm_write,
    output logic              avm_read,
    output logic [7:0]        avm_writedata,
    input  logic              avm_waitrequest,
    input  logic [7:0]        avm_readdata,
    input  logic              avm_readdatavalid
);

    logic              cmd_valid, cmd_wr, cmd_ready, cmd_done;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_wdata, cmd_rdata;

    attr_seq #(.ADDR_W(ADDR_W), .POLL_W(POLL_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_start    (req_start),
        .req_code     (req_code),
        .req_value    (req_value),
        .req_preclear (req_preclear),
        .poll_limit   (poll_limit),
        .cmd_ready    (cmd_ready),
        .cmd_done     (cmd_done),
        .cmd_rdata    (cmd_rdata),
        .cmd_valid    (cmd_valid),
        .cmd_wr       (cmd_wr),
        .cmd_addr     (cmd_addr),
        .cmd_wdata    (cmd_wdata),
        .busy         (busy),
        .done         (done),
        .err_noaccept (err_noaccept),
        .err_timeout  (err_timeout),
        .rd_byte      (rd_byte)
    );

    attr_bus_port #(.ADDR_W(ADDR_W)) u_port (
        .clk               (clk),
        .rst_n             (rst_n),
        .cmd_valid         (cmd_valid),
        .cmd_wr            (cmd_wr),
        .cmd_addr          (cmd_addr),
        .cmd_wdata         (cmd_wdata),
        .cmd_ready         (cmd_ready),
        .cmd_done          (cmd_done),
        .cmd_rdata         (cmd_rdata),
        .avm_address       (avm_address),
        .avm_write         (avm_write),
        .avm_read          (avm_read),
        .avm_writedata     (avm_writedata),
        .avm_waitrequest   (avm_waitrequest),
        .avm_readdata      (avm_readdata),
        .avm_readdatavalid (avm_readdatavalid)
    );

endmodule

// File: tb/attr_cmd_engine_tb.sv
module attr_cmd_engine_tb;

    localparam int ADDR_W = 16;
    localparam int POLL_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_start = 1'b0;
    logic [15:0]       req_code = '0;
    logic [15:0]       req_value = '0;
    logic              req_preclear = 1'b0;
    logic [POLL_W-1:0] poll_limit = '0;
    logic              busy, done, err_noaccept, err_timeout;
    logic [7:0]        rd_byte;
    logic [ADDR_W-1:0] avm_address;
    logic              avm_write, avm_read;
    logic [7:0]        avm_writedata;
    logic              avm_waitrequest;
    logic [7:0]        avm_readdata = '0;
    logic              avm_readdatavalid = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    attr_cmd_engine #(.ADDR_W(ADDR_W), .POLL_W(POLL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_code(req_code),
        .req_value(req_value), .req_preclear(req_preclear), .poll_limit(poll_limit),
        .busy(busy), .done(done), .err_noaccept(err_noaccept), .err_timeout(err_timeout),
        .rd_byte(rd_byte), .avm_address(avm_address), .avm_write(avm_write),
        .avm_read(avm_read), .avm_writedata(avm_writedata),
        .avm_waitrequest(avm_waitrequest), .avm_readdata(avm_readdata),
        .avm_readdatavalid(avm_readdatavalid)
    );

    always #4 clk = ~clk;

    // ---------------- register-space responder ----------------
    bit        accept_en = 1'b1;
    int        busy_len = 0;
    logic [7:0] flag_r = 8'h95;      // starts with a stale set flag
    int        busy_rem = 0;
    int        acc_n = 0;
    int        wcnt = 0;
    logic      rd_pend = 1'b0;
    int        rd_wait = 0;
    logic [7:0] rd_val = '0;
    logic      log_w [64];
    logic [15:0] log_a [64];
    logic [7:0] log_d [64];
    int        log_n = 0;

    assign avm_waitrequest = (avm_read || avm_write) && (wcnt != 0);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        avm_readdatavalid <= 1'b0;
        if (rd_pend) begin
            if (rd_wait == 0) begin
                avm_readdatavalid <= 1'b1;
                avm_readdata      <= rd_val;
                rd_pend           <= 1'b0;
            end else begin
                rd_wait <= rd_wait - 1;
            end
        end
        if (rst_n && (avm_read || avm_write)) begin
            if (wcnt != 0) begin
                wcnt <= wcnt - 1;
            end else begin
                log_w[log_n % 64] <= avm_write;
                log_a[log_n % 64] <= avm_address;
                log_d[log_n % 64] <= avm_writedata;
                log_n <= log_n + 1;
                acc_n <= acc_n + 1;
                wcnt  <= acc_n % 3;
                if (avm_write) begin
                    if (avm_address == 16'h008A && avm_writedata[7]) flag_r[7] <= 1'b0;
                    if (avm_address == 16'h0090 && avm_writedata[0]) begin
                        flag_r   <= accept_en ? 8'h95 : 8'h15;
                        busy_rem <= busy_len;
                    end
                end else begin
                    rd_pend <= 1'b1;
                    rd_wait <= acc_n % 2;
                    if (avm_address == 16'h008A) rd_val <= flag_r;
                    else if (avm_address == 16'h008B) begin
                        rd_val <= {7'b0, busy_rem != 0};
                        if (busy_rem != 0) busy_rem <= busy_rem - 1;
                    end else rd_val <= 8'h00;
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(negedge clk) begin
        if (cycles == 190000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic        exp_w [64];
    logic [15:0] exp_a [64];
    logic [7:0]  exp_d [64];
    int          exp_n;

    task automatic push(input logic w, input logic [15:0] a, input logic [7:0] d);
        exp_w[exp_n] = w;
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_n = exp_n + 1;
    endtask

    task automatic run_case(input logic [15:0] code, input logic [15:0] value,
                            input bit pre, input bit acc, input int blen,
                            input int lim, input bit inj);
        int  base;
        int  lim_eff;
        bit  tmo;
        int  n_polls;
        int  waited;
        bit  busy_bad;
        string rq;
        lim_eff = (lim == 0) ? 1 : lim;
        tmo     = acc && (blen >= lim_eff);
        n_polls = tmo ? lim_eff : blen + 1;
        exp_n = 0;
        if (pre) push(1'b1, 16'h008A, 8'h80);
        push(1'b1, 16'h0084, value[7:0]);
        push(1'b1, 16'h0085, value[15:8]);
        push(1'b1, 16'h0086, code[7:0]);
        push(1'b1, 16'h0087, code[15:8]);
        push(1'b1, 16'h0090, 8'h01);
        push(1'b0, 16'h008A, 8'h00);
        if (acc) begin
            for (int i = 0; i < n_polls; i++) push(1'b0, 16'h008B, 8'h00);
            if (!tmo) push(1'b1, 16'h008A, 8'h80);
        end

        @(negedge clk);
        accept_en    = acc;
        busy_len     = blen;
        base         = log_n;
        req_code     = code;
        req_value    = value;
        req_preclear = pre;
        poll_limit   = POLL_W'(lim);
        req_start    = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        check(busy == 1'b1, "R8", "busy after start", busy, 1);

        waited   = 0;
        busy_bad = 1'b0;
        while (!done && waited < 500) begin
            if (!busy) busy_bad = 1'b1;
            if (inj && waited == 3) begin
                req_start = 1'b1;
                req_code  = ~code;
                req_value = ~value;
            end else begin
                req_start = 1'b0;
            end
            @(negedge clk);
            waited = waited + 1;
        end
        req_start = 1'b0;
        check(done == 1'b1, "R8", "done reached", done, 1);
        check(!busy_bad, "R8", "busy held until done", busy_bad, 0);
        check(busy == 1'b0, "R8", "busy low in done cycle", busy, 0);
        check(err_noaccept == !acc, "R4", "err_noaccept", err_noaccept, !acc);
        check(err_timeout == tmo, "R6", "err_timeout", err_timeout, tmo);
        check(rd_byte == (acc ? 8'h95 : 8'h15), "R7/R10", "rd_byte", rd_byte,
              acc ? 8'h95 : 8'h15);

        rq = !acc ? "R4" : (tmo ? "R6" : "R5");
        check((log_n - base) == exp_n, rq, "access count", log_n - base, exp_n);
        for (int i = 0; i < exp_n && i < (log_n - base); i++) begin
            int k;
            k = (base + i) % 64;
            if (exp_a[i] >= 16'h0084 && exp_a[i] <= 16'h0087) rq = "R1";
            else if (exp_a[i] == 16'h0090) rq = "R2";
            else if (exp_a[i] == 16'h008B) rq = tmo ? "R6" : "R5";
            else if (!exp_w[i]) rq = "R4";
            else if (i == 0 && pre) rq = "R3";
            else rq = "R5";
            check(log_w[k] == exp_w[i] && log_a[k] == exp_a[i] &&
                  (!exp_w[i] || log_d[k] == exp_d[i]), rq, "access",
                  {log_w[k], log_a[k], log_d[k]}, {exp_w[i], exp_a[i], exp_d[i]});
        end

        @(negedge clk);
        check(!done && !err_noaccept && !err_timeout, "R8", "pulses one cycle",
              {done, err_noaccept, err_timeout}, 0);
        if (inj) begin
            repeat (8) @(negedge clk);
            check((log_n - base) == exp_n && !busy, "R9", "no second transaction",
                  log_n - base, exp_n);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !err_noaccept && !err_timeout && !avm_read && !avm_write,
              "R11", "reset outputs", {busy, done, err_noaccept, err_timeout, avm_read, avm_write}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !avm_read && !avm_write, "R11", "idle after reset",
              {busy, avm_read, avm_write}, 0);

        for (int lim = 0; lim < 4; lim++) begin
            for (int blen = 0; blen < 5; blen++) begin
                for (int acc = 0; acc < 2; acc++) begin
                    run_case(16'(16'h0100 * (lim + 1) + 16'h0010 * blen + acc + 16'hA000),
                             16'(16'h3C00 + 16'h0101 * (lim * 5 + blen) + acc * 16'h8000),
                             ((blen + lim) % 2) == 1, acc == 1, blen, lim, blen == 2);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule